// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block resolves one decoded operand at a time for a machine with eight 32-bit data registers and eight 32-bit address registers. A decoder hands it an addressing-mode code, a register number, an optional index register number, a 32-bit instruction constant, a 16-bit displacement and an operand size. The block then does one of two things. It can return the operand at once, from the constant or from a register. Or it can form a memory address, issue a one-cycle read strobe, collect the word the memory returns and hand it back. In either case a done pulse marks the end of the operand.

The block also holds the sixteen-entry register file. Entries 0 to 7 are the data registers and entries 8 to 15 are the address registers. Results computed elsewhere arrive through a write port. The post-increment and pre-decrement modes update their address register by themselves, in the same clock edge that completes the operand. Operand values are zero-extended from the selected size to 32 bits.

Top module: `operand_ea_unit`

## Requirements
- R1: After reset all sixteen registers read as zero, and `done` and `mem_rd` are low.
- R2: Mode code 0 (immediate) returns `imm` masked to the operand size. `done` is high in the cycle after the start edge, and no read strobe is issued.
- R3: Mode code 1 (register direct) returns register `rn` masked to the size. Indices 0-7 select data registers and 8-15 select address registers. It finishes in one cycle with no strobe.
- R4: Mode code 2 (absolute) reads memory at the address `imm`.
- R5: Mode code 3 (indirect) reads memory at address register `rn[2:0]`.
- R6: Mode code 4 (post-increment) reads at the address register's current value. The register then grows by the step, which is 1, 2 or 4 for size codes 0, 1 or 2 (size code 3 also means 4). The register write lands on the edge that raises `done`.
- R7: Mode code 5 (pre-decrement) subtracts the step from the address register and reads at the lowered value. The lowered value is written back on the edge that raises `done`.
- R8: Mode code 6 (displacement) reads at the address register plus `disp`, sign-extended from 16 bits.
- R9: Mode code 7 (indexed) reads at the address register plus the full 32-bit register `xn` (any of the sixteen) plus the sign-extended `disp`.
- R10: For memory modes `mem_rd` is high for exactly the one cycle after the start edge, with `mem_addr` valid. `mem_rdata` is taken in the cycle after the strobe. `done` rises two cycles after the strobe cycle, and `operand` is the returned word masked to the size.
- R11: A `start` that arrives while an operand is in progress is ignored. It produces no strobe, no done and no register change.
- R12: `wr_en` writes `wr_data` into register `wr_idx`. If a mode write-back hits the same register on the same edge, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving an operand |
| mode | input | 3 | Addressing-mode code |
| rn | input | 4 | Register number (direct) or address register in low 3 bits |
| xn | input | 4 | Index register number, any of 16 |
| imm | input | 32 | Instruction constant or absolute address |
| disp | input | 16 | Signed displacement |
| size | input | 2 | Operand size code: 0 byte, 1 half, 2/3 word |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the strobe |
| done | output | 1 | Operand complete pulse |
| operand | output | 32 | Resolved operand value |

## Verification
A wrong step or a wrong adder input shows up as a bad `mem_addr` in the very strobe cycle. A lost or doubled address-register update shows up only later, when the register is read back through register-direct mode or is reused as a base. The bench therefore reads back each modified address register immediately after every side-effecting mode. A state machine that skips or repeats a stage shows up as a moved `done` or strobe cycle, which the bench counts on every operand.

// File: rtl/opea_pkg.sv
package opea_pkg;

    typedef enum logic [2:0] {
        AM_IMM   = 3'd0,
        AM_REG   = 3'd1,
        AM_ABS   = 3'd2,
        AM_IND   = 3'd3,
        AM_POST  = 3'd4,
        AM_PRE   = 3'd5,
        AM_DISP  = 3'd6,
        AM_INDEX = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CAP  = 2'd2
    } st_e;

endpackage

// File: rtl/opea_regfile.sv
module opea_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ra_idx,
    output logic [DW-1:0] ra_val,
    input  logic [RW-1:0] rb_idx,
    output logic [DW-1:0] rb_val,
    input  logic          we_a,
    input  logic [RW-1:0] wa_idx,
    input  logic [DW-1:0] wa_data,
    input  logic          we_b,
    input  logic [RW-1:0] wb_idx,
    input  logic [DW-1:0] wb_data
);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_comb begin
            regs_d[g] = regs_q[g];
            if (we_a && (wa_idx == RW'(g))) regs_d[g] = wa_data;
            if (we_b && (wb_idx == RW'(g))) regs_d[g] = wb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign ra_val = regs_q[ra_idx];
    assign rb_val = regs_q[rb_idx];

    AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_b |=> (regs_q[$past(wb_idx)] == $past(wb_data))); // R12
    AST_EXT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && !(we_b && (wb_idx == wa_idx))) |=> (regs_q[$past(wa_idx)] == $past(wa_data))); // R12

endmodule

// File: rtl/opea_addr_calc.sv
module opea_addr_calc
    import opea_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DISPW = 16
) (
    input  am_e           mode,
    input  logic [1:0]    size,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] idx_val,
    input  logic [DW-1:0] imm,
    input  logic [DISPW-1:0] disp,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] base_next,
    output logic          base_wr,
    output logic          is_mem
);

    logic [DW-1:0] step;
    logic [DW-1:0] disp_x;
    logic [DW-1:0] dec_val;

    always_comb begin
        case (size)
            2'd0:    step = DW'(1);
            2'd1:    step = DW'(2);
            default: step = DW'(4);
        endcase
    end

    assign disp_x  = {{(DW-DISPW){disp[DISPW-1]}}, disp};
    assign dec_val = base_val - step;

    always_comb begin
        ea        = base_val;
        base_next = base_val;
        base_wr   = 1'b0;
        is_mem    = 1'b1;
        case (mode)
            AM_IMM, AM_REG: is_mem = 1'b0;
            AM_ABS:   ea = imm;
            AM_IND:   ea = base_val;
            AM_POST: begin
                ea        = base_val;
                base_next = base_val + step;
                base_wr   = 1'b1;
            end
            AM_PRE: begin
                ea        = dec_val;
                base_next = dec_val;
                base_wr   = 1'b1;
            end
            AM_DISP:  ea = base_val + disp_x;
            AM_INDEX: ea = base_val + idx_val + disp_x;
            default:  ea = base_val;
        endcase
    end

endmodule

// File: rtl/operand_ea_unit.sv
module operand_ea_unit
    import opea_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NDATA = 8,
    parameter int NADDR = 8,
    parameter int DISPW = 16,
    localparam int NREG = NDATA + NADDR,
    localparam int RW   = $clog2(NREG),
    localparam int AW   = $clog2(NADDR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [RW-1:0]    rn,
    input  logic [RW-1:0]    xn,
    input  logic [DW-1:0]    imm,
    input  logic [DISPW-1:0] disp,
    input  logic [1:0]       size,
    input  logic             wr_en,
    input  logic [RW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    output logic             mem_rd,
    output logic [DW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done,
    output logic [DW-1:0]    operand
);

    typedef struct packed {
        st_e           st;
        logic          mem_rd;
        logic [DW-1:0] addr;
        logic [DW-1:0] opnd;
        logic          done;
        logic          wb_pend;
        logic [AW-1:0] wb_reg;
        logic [DW-1:0] wb_val;
        logic [1:0]    size;
    } ctl_t;

    ctl_t q, d;

    am_e           mode_e;
    logic [RW-1:0] ra_idx;
    logic [DW-1:0] ra_val;
    logic [DW-1:0] rb_val;
    logic [DW-1:0] ea;
    logic [DW-1:0] base_next;
    logic          base_wr;
    logic          is_mem;
    logic          wb_fire;
    logic [RW-1:0] wb_idx;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic [1:0] sz);
        case (sz)
            2'd0:    return v & DW'(8'hFF);
            2'd1:    return v & DW'(16'hFFFF);
            default: return v;
        endcase
    endfunction

    assign mode_e = am_e'(mode);
    assign ra_idx = (mode_e == AM_REG) ? rn : (RW'(NDATA) + RW'(rn[AW-1:0]));

    opea_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (ra_idx),
        .ra_val  (ra_val),
        .rb_idx  (xn),
        .rb_val  (rb_val),
        .we_a    (wr_en),
        .wa_idx  (wr_idx),
        .wa_data (wr_data),
        .we_b    (wb_fire),
        .wb_idx  (wb_idx),
        .wb_data (q.wb_val)
    );

    opea_addr_calc #(.DW(DW), .DISPW(DISPW)) u_calc (
        .mode      (mode_e),
        .size      (size),
        .base_val  (ra_val),
        .idx_val   (rb_val),
        .imm       (imm),
        .disp      (disp),
        .ea        (ea),
        .base_next (base_next),
        .base_wr   (base_wr),
        .is_mem    (is_mem)
    );

    assign wb_fire = (q.st == ST_CAP) && q.wb_pend;
    assign wb_idx  = RW'(NDATA) + RW'(q.wb_reg);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.mem_rd = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (is_mem) begin
                        d.st      = ST_RD;
                        d.mem_rd  = 1'b1;
                        d.addr    = ea;
                        d.wb_pend = base_wr;
                        d.wb_reg  = rn[AW-1:0];
                        d.wb_val  = base_next;
                        d.size    = size;
                    end else begin
                        d.done = 1'b1;
                        d.opnd = fit((mode_e == AM_IMM) ? imm : ra_val, size);
                    end
                end
            end
            ST_RD: d.st = ST_CAP;
            ST_CAP: begin
                d.st      = ST_IDLE;
                d.done    = 1'b1;
                d.opnd    = fit(mem_rdata, q.size);
                d.wb_pend = 1'b0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_rd   = q.mem_rd;
    assign mem_addr = q.addr;
    assign done     = q.done;
    assign operand  = q.opnd;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R10
    AST_READ_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ##1 done); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> $stable(mem_addr)); // R10
    AST_REGONLY_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (q.st == ST_IDLE) && (mode_e inside {AM_IMM, AM_REG})) |=> (done && !mem_rd)); // R2
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_fire |=> done); // R6
    AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> !mem_rd); // R11

endmodule

// File: tb/operand_ea_unit_tb.sv
module operand_ea_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [3:0]  rn = '0;
    logic [3:0]  xn = '0;
    logic [31:0] imm = '0;
    logic [15:0] disp = '0;
    logic [1:0]  size = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] operand;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic [31:0] mdl [16];

    always #2 clk = ~clk;

    operand_ea_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rn(rn), .xn(xn),
        .imm(imm), .disp(disp), .size(size), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .operand(operand)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hA5C3_0F96;
    endfunction

    function automatic logic [31:0] fitb(input logic [31:0] v, input logic [1:0] sz);
        if (sz == 2'd0) return {24'd0, v[7:0]};
        if (sz == 2'd1) return {16'd0, v[15:0]};
        return v;
    endfunction

    function automatic logic [31:0] stepb(input logic [1:0] sz);
        if (sz == 2'd0) return 32'd1;
        if (sz == 2'd1) return 32'd2;
        return 32'd4;
    endfunction

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired got=%0d exp<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] i, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[i] = v;
    endtask

    task automatic do_op(input logic [2:0] md, input logic [3:0] r, input logic [3:0] x,
                         input logic [31:0] im, input logic [15:0] dp, input logic [1:0] sz,
                         output logic [31:0] opv, output logic [31:0] adr,
                         output int rd_cyc, output int dn_cyc, output int rd_cnt);
        opv = '0; adr = '0; rd_cyc = 0; dn_cyc = 0; rd_cnt = 0;
        @(negedge clk);
        start = 1'b1; mode = md; rn = r; xn = x; imm = im; disp = dp; size = sz;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k < 10; k++) begin
            if (mem_rd) begin
                rd_cnt++;
                if (rd_cyc == 0) rd_cyc = k;
                adr = mem_addr;
            end
            if (done) begin
                dn_cyc = k;
                opv = operand;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic readback(input logic [3:0] r, input string tag);
        logic [31:0] o, a;
        int rc, dc, cnt;
        do_op(3'd1, r, 4'd0, 32'd0, 16'd0, 2'd2, o, a, rc, dc, cnt);
        chk(tag, o, mdl[r]);
    endtask

    task automatic mem_mode(input logic [2:0] md, input logic [2:0] ar, input logic [3:0] x,
                            input logic [31:0] im, input logic [15:0] dp, input logic [1:0] sz,
                            input string tag);
        logic [31:0] o, a, base, ex_a, dx;
        int rc, dc, cnt;
        base = mdl[4'd8 + 4'(ar)];
        dx   = {{16{dp[15]}}, dp};
        case (md)
            3'd2:    ex_a = im;
            3'd5:    ex_a = base - stepb(sz);
            3'd6:    ex_a = base + dx;
            3'd7:    ex_a = base + mdl[x] + dx;
            default: ex_a = base;
        endcase
        do_op(md, {1'b0, ar}, x, im, dp, sz, o, a, rc, dc, cnt);
        chk({tag, " addr"}, a, ex_a);
        chk("R10 strobe cycle", 32'(rc), 32'd1);
        chk("R10 strobe count", 32'(cnt), 32'd1);
        chk("R10 done cycle", 32'(dc), 32'd3);
        chk("R10 operand", o, fitb(memf(ex_a), sz));
        if (md == 3'd4) mdl[4'd8 + 4'(ar)] = base + stepb(sz);
        if (md == 3'd5) mdl[4'd8 + 4'(ar)] = ex_a;
        if (md == 3'd4) readback(4'd8 + 4'(ar), "R6 address register after post-increment");
        if (md == 3'd5) readback(4'd8 + 4'(ar), "R7 address register after pre-decrement");
    endtask

    initial begin
        logic [31:0] o, a;
        int rc, dc, cnt;
        logic [15:0] dlist [4];
        logic [3:0]  xlist [4];
        dlist[0] = 16'h0008; dlist[1] = 16'hFFFC; dlist[2] = 16'h7FFF; dlist[3] = 16'h8000;
        xlist[0] = 4'd2; xlist[1] = 4'd5; xlist[2] = 4'd9; xlist[3] = 4'd15;
        for (int i = 0; i < 16; i++) mdl[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 mem_rd after reset", 32'(mem_rd), 32'd0);
        for (int i = 0; i < 16; i++) readback(4'(i), "R1 register zero after reset");

        for (int i = 0; i < 8; i++) wreg(4'(i), 32'hD000_0000 | (32'(i) * 32'h0101_0301));
        wreg(4'd5, 32'hFFFF_FFF0);
        for (int j = 0; j < 8; j++) wreg(4'(8 + j), 32'h0000_1000 + 32'(j) * 32'h0000_0100);
        for (int i = 0; i < 16; i++) readback(4'(i), "R12 write port value");

        for (int s = 0; s < 3; s++) begin
            do_op(3'd0, 4'd0, 4'd0, 32'h89AB_CDEF, 16'd0, 2'(s), o, a, rc, dc, cnt);
            chk("R2 immediate operand", o, fitb(32'h89AB_CDEF, 2'(s)));
            chk("R2 immediate done cycle", 32'(dc), 32'd1);
            chk("R2 immediate no strobe", 32'(cnt), 32'd0);
            for (int r = 0; r < 16; r++) begin
                do_op(3'd1, 4'(r), 4'd0, 32'd0, 16'd0, 2'(s), o, a, rc, dc, cnt);
                chk("R3 register direct operand", o, fitb(mdl[r], 2'(s)));
                chk("R3 register direct done cycle", 32'(dc), 32'd1);
                chk("R3 register direct no strobe", 32'(cnt), 32'd0);
            end
        end

        for (int s = 0; s < 4; s++) begin
            for (int ar = 0; ar < 8; ar += 3) begin
                mem_mode(3'd2, 3'(ar), 4'd0, 32'h0002_0000 + 32'(ar * 4 + s), 16'd0, 2'(s), "R4 absolute");
                mem_mode(3'd3, 3'(ar), 4'd0, 32'd0, 16'd0, 2'(s), "R5 indirect");
                mem_mode(3'd4, 3'(ar), 4'd0, 32'd0, 16'd0, 2'(s), "R6 post-increment");
                mem_mode(3'd5, 3'(ar), 4'd0, 32'd0, 16'd0, 2'(s), "R7 pre-decrement");
                for (int k = 0; k < 4; k++) begin
                    mem_mode(3'd6, 3'(ar), 4'd0, 32'd0, dlist[k], 2'(s), "R8 displacement");
                    for (int m = 0; m < 4; m++)
                        mem_mode(3'd7, 3'(ar), xlist[m], 32'd0, dlist[k], 2'(s), "R9 indexed");
                end
            end
        end

        // R11: second start while an indirect read is in flight
        @(negedge clk);
        start = 1'b1; mode = 3'd3; rn = 4'd0; size = 2'd2;
        @(negedge clk);
        mode = 3'd4; rn = 4'd1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R11 first operand done", 32'(done), 32'd1);
        chk("R11 first operand value", operand, memf(mdl[8]));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 no extra strobe", 32'(mem_rd), 32'd0);
            chk("R11 no extra done", 32'(done), 32'd0);
        end
        readback(4'd9, "R11 ignored start left register unchanged");

        // R12: external write to the same register on the write-back edge
        @(negedge clk);
        start = 1'b1; mode = 3'd4; rn = 4'd2; size = 2'd2;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd10; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R12 done on write-back edge", 32'(done), 32'd1);
        mdl[10] = mdl[10] + 32'd4;
        readback(4'd10, "R12 write-back wins over port write");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule